// File: doc/BRIEF.md
# Extended-frame SPI ADC reader

This block is an SPI master for a serial successive-approximation converter whose conversion frame is longer than 16 clocks. A single chip-select assertion covers the whole frame. The first clocks let the converter sample its input and carry nothing useful. The clocks that follow deliver the 16-bit result, most significant bit first. The block runs the frame in one piece, throws away the bits that arrive during the sampling clocks, and hands the result to the parallel side with a one-cycle done pulse.

A frame starts from a start request. The SCLK half-period is set by a divider input, counted in system clocks. After each frame, chip select stays high for a minimum recovery time, also set by an input. If start is held high, conversions follow one another back to back at that minimum spacing. A start request made during a frame or during the recovery time has no effect.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset cs_n_o is 1, sclk_o is 0, done_o is 0 and data_o is 0.
- R2: Each frame gives exactly 22 rising SCLK edges (6 lead plus 16 data), and cs_n_o stays 0 from the first edge to the last.
- R3: The SCLK half-period is half_div_i+1 system clocks. cs_n_o falls one half-period before the first rising edge and rises one half-period after the last falling edge, so cs_n_o is low for 45*(half_div_i+1) clocks.
- R4: The bits on miso_i at rising edges 1 to 6 never reach data_o, whatever their values.
- R5: miso_i is sampled on SCLK rising edges. Edge 7 gives data_o[15], and so on down to edge 22, which gives data_o[0]. The converter changes miso_i after falling edges.
- R6: done_o is a single-cycle pulse in the same cycle that cs_n_o returns to 1. data_o shows the new result from that cycle and holds it until the next done_o.
- R7: A start_i pulse while a frame or the recovery gap is in progress is ignored: it neither restarts the frame nor adds a frame.
- R8: Between frames cs_n_o stays high for at least gap_i+2 clocks. With start_i held high, it stays high for exactly gap_i+2 clocks.
- R9: sclk_o is 0 whenever cs_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, acted on only when idle |
| half_div_i | input | DIV_W | SCLK half-period minus one, in system clocks |
| gap_i | input | GAP_W | Recovery time setting; cs_n_o high for at least gap_i+2 clocks |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, low when idle |
| cs_n_o | output | 1 | Active-low chip select |
| data_o | output | DATA_BITS | Last captured result |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The converter model drives random result words and three kinds of lead bits: random, all ones and all zeros. A result that changes with the lead bits shows a leak of lead bits into the result. Words such as 0x8001 and 0x7FFE show whether the bit order is reversed or shifted by one. Random divider values from 0 to 3 separate a correct half-period from an off-by-one error in the frame length and in the setup time before the first edge. Start is also pulsed in the middle of a frame, and held high across frames, to check that extra requests are ignored and that the back-to-back spacing is exact.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLK,
        ST_HOLD,
        ST_GAP
    } rd_state_e;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign tick_o = en_i && (cnt_q == limit_i);

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         sample_i,
    input  logic         bit_i,
    output logic [N-1:0] word_o
);
    logic [N-1:0] word_d, word_q;

    assign word_o = word_q;

    always_comb begin
        word_d = word_q;
        if (clear_i)       word_d = '0;
        else if (sample_i) word_d = {word_q[N-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int GAP_W     = 4,
    parameter int LEAD_BITS = 6,
    parameter int DATA_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DIV_W-1:0]     half_div_i,
    input  logic [GAP_W-1:0]     gap_i,
    input  logic                 miso_i,
    output logic                 sclk_o,
    output logic                 cs_n_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 done_o
);
    localparam int TOTAL  = LEAD_BITS + DATA_BITS;
    localparam int EDGES  = 2 * TOTAL;
    localparam int EDGE_W = $clog2(EDGES + 1);

    typedef struct packed {
        rd_state_e            st;
        logic                 sclk;
        logic                 cs_n;
        logic [EDGE_W-1:0]    edge_n;
        logic [GAP_W-1:0]     gcnt;
        logic                 done;
        logic [DATA_BITS-1:0] dout;
    } ctl_t;

    localparam ctl_t C_RST = '{st: ST_IDLE, sclk: 1'b0, cs_n: 1'b1,
                               edge_n: '0, gcnt: '0, done: 1'b0, dout: '0};

    ctl_t c_d, c_q;
    logic tick;
    logic tick_en;
    logic take_bit;
    logic accept;
    logic [DATA_BITS-1:0] word;

    assign tick_en = (c_q.st == ST_SETUP) || (c_q.st == ST_CLK) || (c_q.st == ST_HOLD);
    assign accept  = (c_q.st == ST_IDLE) && start_i;
    // Rising edge about to be issued, past the lead (sampling) clocks
    assign take_bit = tick && !c_q.sclk
                      && ((c_q.st == ST_SETUP) || (c_q.st == ST_CLK))
                      && ((c_q.edge_n >> 1) >= EDGE_W'(LEAD_BITS));

    adc_rd_tick #(.W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (tick_en),
        .limit_i (half_div_i),
        .tick_o  (tick)
    );

    adc_rd_shift #(.N(DATA_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .sample_i (take_bit),
        .bit_i    (miso_i),
        .word_o   (word)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.st     = ST_SETUP;
                    c_d.cs_n   = 1'b0;
                    c_d.edge_n = '0;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    c_d.st     = ST_CLK;
                    c_d.sclk   = 1'b1;
                    c_d.edge_n = EDGE_W'(1);
                end
            end
            ST_CLK: begin
                if (tick) begin
                    c_d.sclk   = ~c_q.sclk;
                    c_d.edge_n = c_q.edge_n + EDGE_W'(1);
                    if (c_q.edge_n == EDGE_W'(EDGES - 1)) c_d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    c_d.st   = ST_GAP;
                    c_d.cs_n = 1'b1;
                    c_d.done = 1'b1;
                    c_d.dout = word;
                    c_d.gcnt = '0;
                end
            end
            ST_GAP: begin
                if (c_q.gcnt == gap_i) c_d.st = ST_IDLE;
                else                   c_d.gcnt = c_q.gcnt + GAP_W'(1);
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= C_RST;
        else        c_q <= c_d;
    end

    assign sclk_o = c_q.sclk;
    assign cs_n_o = c_q.cs_n;
    assign data_o = c_q.dout;
    assign done_o = c_q.done;
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
    parameter int GAP_W = 4,
    parameter int TOTAL = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_o,
    input logic             cs_n_o,
    input logic             done_o,
    input logic [GAP_W-1:0] gap_i
);
    localparam int HW = GAP_W + 2;
    localparam int RW = $clog2(TOTAL + 2);

    logic          sclk_prev;
    logic [RW-1:0] rises_q;
    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            rises_q   <= '0;
            hi_q      <= '1;
        end else begin
            sclk_prev <= sclk_o;
            if (cs_n_o)                      rises_q <= '0;
            else if (sclk_o && !sclk_prev)   rises_q <= rises_q + RW'(1);
            if (!cs_n_o)                     hi_q <= '0;
            else if (hi_q != '1)             hi_q <= hi_q + HW'(1);
        end
    end

    p_sclk_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    p_edge_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (rises_q == RW'(TOTAL)));

    p_done_at_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(cs_n_o));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_min_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_q >= ({2'b00, gap_i} + HW'(2))));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
    .GAP_W (GAP_W),
    .TOTAL (LEAD_BITS + DATA_BITS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_o (sclk_o),
    .cs_n_o (cs_n_o),
    .done_o (done_o),
    .gap_i  (gap_i)
);

// File: tb/adc_frame_reader_test.sv
module adc_frame_reader_test;
    localparam int DIV_W = 8;
    localparam int GAP_W = 4;
    localparam int LEAD  = 6;
    localparam int DBITS = 16;
    localparam int TOTAL = LEAD + DBITS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [DIV_W-1:0] half_div_i = '0;
    logic [GAP_W-1:0] gap_i = '0;
    logic             miso_i = 1'b0;
    logic             sclk_o, cs_n_o, done_o;
    logic [DBITS-1:0] data_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    adc_frame_reader #(.DIV_W(DIV_W), .GAP_W(GAP_W), .LEAD_BITS(LEAD), .DATA_BITS(DBITS)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_div_i(half_div_i),
        .gap_i(gap_i), .miso_i(miso_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
        .data_o(data_o), .done_o(done_o));

    // Converter model: presents the next bit after each falling SCLK edge
    logic [DBITS-1:0] adc_word = '0;
    int  junk_mode = 0;
    bit  open_f = 0;
    int  fcnt = 0;

    function automatic logic lead_bit();
        if (junk_mode == 1) return 1'b1;
        if (junk_mode == 2) return 1'b0;
        return 1'($urandom & 1);
    endfunction

    task automatic drive_for_rise(int r);
        if (r > LEAD && r <= TOTAL) miso_i = adc_word[TOTAL - r];
        else                        miso_i = lead_bit();
    endtask

    always @(negedge sclk_o or negedge cs_n_o or posedge cs_n_o) begin
        if (cs_n_o) open_f = 0;
        else if (!open_f) begin
            open_f = 1; fcnt = 0; drive_for_rise(1);
        end else begin
            fcnt++; drive_for_rise(fcnt + 1);
        end
    end

    // Port monitor, sampled shortly after each active edge
    int  low_cyc = 0, rises = 0, first_rise = 0, frames = 0, r9_bad = 0;
    logic cs_prev = 1'b1, sclk_prev = 1'b0;
    always @(posedge clk) begin
        #2;
        if (!cs_n_o) begin
            if (cs_prev) begin low_cyc = 0; rises = 0; frames++; end
            low_cyc++;
            if (sclk_o && !sclk_prev) begin
                rises++;
                if (rises == 1) first_rise = low_cyc;
            end
        end
        if (cs_n_o && sclk_o) r9_bad++;
        cs_prev = cs_n_o; sclk_prev = sclk_o;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic int exp_low(int hd);
        return (2 * TOTAL + 1) * (hd + 1);
    endfunction

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done_o) begin ok = 1; break; end
        end
        if (!ok) chk(0, "watchdog wait for done", 0, 1);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame(logic [DBITS-1:0] w, int hd, int gp, int jm, bit mid_start);
        bit ok;
        @(negedge clk);
        adc_word = w; junk_mode = jm;
        half_div_i = DIV_W'(hd); gap_i = GAP_W'(gp);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mid_start) begin
            idle(15);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        end
        wait_done(ok);
        if (!ok) return;
        chk(data_o == w, "R5 R4 captured word", int'(data_o), int'(w));
        chk(rises == TOTAL, "R2 SCLK rising edges", rises, TOTAL);
        chk(low_cyc == exp_low(hd), "R3 cs_n low clocks", low_cyc, exp_low(hd));
        chk(first_rise == hd + 2, "R3 setup before first edge", first_rise, hd + 2);
        chk(cs_n_o == 1'b1, "R6 cs_n high with done", int'(cs_n_o), 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done single cycle", int'(done_o), 0);
        idle(20);
        chk(data_o == w, "R6 data held", int'(data_o), int'(w));
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        int nfr;
        bit ok;
        int hi;
        logic [DBITS-1:0] w;
        idle(3);
        chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R1 reset cs_n/sclk", {cs_n_o, sclk_o}, 2);
        chk(done_o == 1'b0 && data_o == '0, "R1 reset done/data", int'(data_o), 0);
        rst_n = 1'b1;
        idle(5);
        chk(cs_n_o == 1'b1 && done_o == 1'b0, "R1 idle after reset", int'(cs_n_o), 1);

        // directed corners
        frame(16'h0000, 0, 0, 1, 0);   // R4 lead bits all ones
        frame(16'hFFFF, 1, 3, 2, 0);   // R4 lead bits all zeros
        frame(16'h8001, 2, 5, 0, 0);   // R5 order
        frame(16'h7FFE, 3, 15, 1, 0);

        // R7: start pulse mid frame ignored
        nfr = frames;
        frame(16'hA5C3, 1, 4, 0, 1);
        chk(frames == nfr + 1, "R7 extra start ignored", frames - nfr, 1);
        chk(cs_n_o == 1'b1, "R7 no new frame", int'(cs_n_o), 1);

        // R8: back-to-back with start held
        @(negedge clk);
        adc_word = 16'h1234; junk_mode = 0; half_div_i = 8'd0; gap_i = 4'd7;
        start_i = 1'b1;
        wait_done(ok);
        if (ok) begin
            chk(data_o == 16'h1234, "R5 back-to-back first word", int'(data_o), 16'h1234);
            hi = 1;
            adc_word = 16'hBEEF;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (!cs_n_o) break;
                hi++;
            end
            chk(hi == 7 + 2, "R8 back-to-back gap", hi, 9);
            start_i = 1'b0;
            wait_done(ok);
            if (ok) chk(data_o == 16'hBEEF, "R5 back-to-back second word", int'(data_o), 16'hBEEF);
        end
        idle(25);

        // constrained random
        void'($urandom(32'd4711));
        for (int k = 0; k < 20; k++) begin
            w = DBITS'($urandom);
            frame(w, int'($urandom % 4), int'($urandom % 16), int'($urandom % 3), 0);
        end

        chk(r9_bad == 0, "R9 sclk low while cs_n high", r9_bad, 0);
        summary();
    end

    initial begin
        #1;
        rst_n = 1'b0;
    end
endmodule